// File: doc/BRIEF.md
# Per-Type Functional Unit Arbiter for Multi-Hart Vector Coprocessor

This block decides which of several hardware threads (harts) may start a vector operation on which functional unit of a shared vector coprocessor. Each hart raises a request together with the code of the unit type it needs, for example 0 for the adder, 1 for the multiplier and 2 for the shifter. It keeps that request up until a grant arrives. Each hart has its own scratchpad address space, so the only things that can collide are the functional units. When a unit finishes its operation, it reports done on its own done line. The datapaths of the units are outside this block.

A parameter selects one of three sharing schemes. In whole-coprocessor sharing, one granted operation blocks every other request until it completes. In per-hart ownership, every hart has a private set of units and waits only on its own busy unit. In per-type sharing, only harts that ask for the same unit type contend with each other. Harts that ask for different types are granted in the same cycle. Grants and stalls are combinational in the request cycle. Unit occupancy is registered.

Top module: `vfu_share_arb`

## Requirements
- R1: After reset every busy_o bit is 0 and no grant is issued without a request. Every round-robin pointer points at hart 0 after reset.
- R2: In per-type mode (SHARE_BY_TYPE), a valid request for a unit type whose unit is free is granted in the same cycle. Harts asking for different free types are all granted in that cycle.
- R3: A valid request that is not granted raises that hart's stall_o in the same cycle. stall_o stays high in every cycle until the grant comes. grant_o and stall_o are never high together for one hart.
- R4: When several harts ask for the same free unit in one cycle, exactly one wins. The search starts at the hart after the previous winner for that unit type, or at hart 0 if there has been no winner since reset.
- R5: busy_o bit (row*NUM_FU + type) rises in the cycle after a grant, where row is the hart in per-hart mode and 0 otherwise. The bit stays high until done_i for that bit is seen. It falls in the following cycle, and a new grant for that unit is possible only from that cycle on.
- R6: done_i for a unit that is not busy has no effect.
- R7: In whole-coprocessor mode (SHARE_ALL), at most one unit is busy at a time. While any unit is busy, every request stalls, whatever its type. Free requests compete through a single round-robin pointer.
- R8: In per-hart mode (SHARE_DEDICATED), each hart uses the units in its own row. Harts never block one another. A hart stalls only when its own unit of the requested type is busy.
- R9: A request whose type code is NUM_FU or higher is ignored. It receives no grant, no stall and changes no busy bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_HARTS | Request per hart, held until granted |
| req_fu_i | input | NUM_HARTS*FW | Unit type code per hart, hart h in bits [h*FW +: FW] |
| done_i | input | NUM_HARTS*NUM_FU | Completion per unit, same bit layout as busy_o |
| grant_o | output | NUM_HARTS | Grant per hart, same cycle as the request |
| stall_o | output | NUM_HARTS | Hart is waiting for its grant |
| busy_o | output | NUM_HARTS*NUM_FU | Unit occupied, bit row*NUM_FU + type |

## Verification
grant_o and stall_o answer a request in the same cycle. The bench therefore drives inputs on the falling edge and compares these outputs one nanosecond later. busy_o is due one rising edge after a grant or a done, so each vector's expected busy value is the occupancy produced by the previous vectors. That value is checked on the falling edge before new stimulus is applied. Release behaviour is checked in two cycles: in the done cycle the waiting hart must still stall, and only in the next cycle may it be granted.

// File: rtl/vfu_arb_pkg.sv
package vfu_arb_pkg;

    typedef enum logic [1:0] {
        SHARE_ALL       = 2'd0,
        SHARE_DEDICATED = 2'd1,
        SHARE_BY_TYPE   = 2'd2
    } share_mode_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vfu_rr_pick.sv
module vfu_rr_pick #(
    parameter int NUM_REQ = 3,
    parameter int IW      = 2
) (
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [IW-1:0]      ptr_i,
    output logic [NUM_REQ-1:0] win_oh_o,
    output logic [IW-1:0]      win_idx_o,
    output logic               any_o
);

    always_comb begin
        win_oh_o  = '0;
        win_idx_o = '0;
        any_o     = 1'b0;
        for (int k = 0; k < NUM_REQ; k++) begin
            int cand;
            cand = int'(ptr_i) + k;
            if (cand >= NUM_REQ) cand = cand - NUM_REQ;
            if (!any_o && req_i[cand]) begin
                any_o          = 1'b1;
                win_oh_o[cand] = 1'b1;
                win_idx_o      = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/vfu_unit_slot.sv
module vfu_unit_slot (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic take_i,
    input  logic done_i,
    output logic busy_o
);

    logic busy_d, busy_q;

    always_comb begin
        busy_d = busy_q;
        if (take_i)                busy_d = 1'b1;
        else if (busy_q && done_i) busy_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) busy_q <= 1'b0;
        else         busy_q <= busy_d;
    end

    assign busy_o = busy_q;

    AST_TAKE_FREE:   assert property (@(posedge clk_i) disable iff (!rst_ni) take_i |-> !busy_q);              // R2
    AST_HOLD_BUSY:   assert property (@(posedge clk_i) disable iff (!rst_ni) (busy_q && !done_i) |=> busy_q);   // R5
    AST_RELEASE:     assert property (@(posedge clk_i) disable iff (!rst_ni) (busy_q && done_i) |=> !busy_q);   // R5
    AST_IDLE_DONE:   assert property (@(posedge clk_i) disable iff (!rst_ni) (!busy_q && !take_i) |=> !busy_q); // R6

endmodule

// File: rtl/vfu_share_arb.sv
module vfu_share_arb
    import vfu_arb_pkg::*;
#(
    parameter int          NUM_HARTS  = 3,
    parameter int          NUM_FU     = 3,
    parameter share_mode_e SHARE_MODE = SHARE_BY_TYPE
) (
    input  logic                                    clk_i,
    input  logic                                    rst_ni,
    input  logic [NUM_HARTS-1:0]                    req_i,
    input  logic [NUM_HARTS*idx_width(NUM_FU)-1:0]  req_fu_i,
    input  logic [NUM_HARTS*NUM_FU-1:0]             done_i,
    output logic [NUM_HARTS-1:0]                    grant_o,
    output logic [NUM_HARTS-1:0]                    stall_o,
    output logic [NUM_HARTS*NUM_FU-1:0]             busy_o
);

    localparam int FW    = idx_width(NUM_FU);
    localparam int HW    = idx_width(NUM_HARTS);
    localparam int NSLOT = NUM_HARTS * NUM_FU;

    typedef struct packed {
        logic [NUM_FU-1:0][HW-1:0] rr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_HARTS-1:0][FW-1:0]      fu_type;
    logic [NUM_HARTS-1:0]              req_ok;
    logic [NUM_FU-1:0][NUM_HARTS-1:0]  pick_req;
    logic [NUM_FU-1:0][NUM_HARTS-1:0]  pick_oh;
    logic [NUM_FU-1:0][HW-1:0]         pick_idx;
    logic [NUM_FU-1:0]                 pick_any;
    logic [NSLOT-1:0]                  take;
    logic [NSLOT-1:0]                  busy;
    logic [NUM_HARTS-1:0]              grant;

    function automatic logic [HW-1:0] ptr_after(input logic [HW-1:0] idx);
        return (idx == HW'(NUM_HARTS - 1)) ? '0 : idx + 1'b1;
    endfunction

    // decode the per-hart type codes and drop out-of-range ones
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_dec
        assign fu_type[h] = req_fu_i[h*FW +: FW];
        assign req_ok[h]  = req_i[h] && ({1'b0, fu_type[h]} < (FW+1)'(NUM_FU));
    end

    // candidate sets per picker: one per unit type, or one global set
    always_comb begin
        pick_req = '0;
        for (int f = 0; f < NUM_FU; f++) begin
            for (int h = 0; h < NUM_HARTS; h++) begin
                if (SHARE_MODE == SHARE_ALL) begin
                    pick_req[f][h] = (f == 0) && req_ok[h];
                end else begin
                    pick_req[f][h] = req_ok[h] && (int'(fu_type[h]) == f);
                end
            end
        end
    end

    for (genvar f = 0; f < NUM_FU; f++) begin : g_pick
        vfu_rr_pick #(
            .NUM_REQ (NUM_HARTS),
            .IW      (HW)
        ) u_pick (
            .req_i     (pick_req[f]),
            .ptr_i     (st_q.rr[f]),
            .win_oh_o  (pick_oh[f]),
            .win_idx_o (pick_idx[f]),
            .any_o     (pick_any[f])
        );
    end

    always_comb begin
        st_d  = st_q;
        grant = '0;
        take  = '0;
        unique case (SHARE_MODE)
            SHARE_BY_TYPE: begin
                for (int f = 0; f < NUM_FU; f++) begin
                    if (!busy[f] && pick_any[f]) begin
                        grant       = grant | pick_oh[f];
                        take[f]     = 1'b1;
                        st_d.rr[f]  = ptr_after(pick_idx[f]);
                    end
                end
            end
            SHARE_DEDICATED: begin
                for (int h = 0; h < NUM_HARTS; h++) begin
                    int slot;
                    slot = h * NUM_FU + int'(fu_type[h]);
                    if (req_ok[h] && !busy[slot]) begin
                        grant[h]   = 1'b1;
                        take[slot] = 1'b1;
                    end
                end
            end
            default: begin
                if (!(|busy[NUM_FU-1:0]) && pick_any[0]) begin
                    grant      = pick_oh[0];
                    st_d.rr[0] = ptr_after(pick_idx[0]);
                    for (int h = 0; h < NUM_HARTS; h++) begin
                        if (pick_oh[0][h]) take[int'(fu_type[h])] = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar u = 0; u < NSLOT; u++) begin : g_slot
        vfu_unit_slot u_slot (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .take_i (take[u]),
            .done_i (done_i[u]),
            .busy_o (busy[u])
        );
    end

    assign grant_o = grant;
    assign stall_o = req_ok & ~grant;
    assign busy_o  = busy;

    AST_GRANT_NOT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni) (grant_o & stall_o) == '0); // R3
    AST_GRANT_HAS_REQ:   assert property (@(posedge clk_i) disable iff (!rst_ni) (grant_o & ~req_i) == '0);  // R1
    AST_STALL_PERSIST:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                             (stall_o[0] && req_i[0] && $stable(req_fu_i)) |=> (stall_o[0] || grant_o[0] || !req_i[0])); // R3
    AST_BAD_TYPE_QUIET:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                             (req_i[0] && !req_ok[0]) |-> (!grant_o[0] && !stall_o[0])); // R9

    if (SHARE_MODE == SHARE_ALL) begin : g_ast_all
        AST_ONE_BUSY:  assert property (@(posedge clk_i) disable iff (!rst_ni) $countones(busy_o) <= 1); // R7
        AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(grant_o));       // R7
    end
    if (SHARE_MODE == SHARE_BY_TYPE) begin : g_ast_type
        AST_ROW0_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
                           busy_o[NSLOT-1:NUM_FU] == '0); // R5
    end

endmodule

// File: tb/vfu_share_arb_bench.sv
`timescale 1ns/1ps
module vfu_share_arb_bench;
    import vfu_arb_pkg::*;

    localparam int  H = 3;
    localparam int  F = 3;
    localparam time CLK_PERIOD = 8ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req = '0;
    logic [5:0] fu = '0;
    logic [8:0] done = '0;
    logic [2:0] gnt_t, stl_t, gnt_d, stl_d, gnt_a, stl_a;
    logic [8:0] bsy_t, bsy_d, bsy_a;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vfu_share_arb #(.NUM_HARTS(H), .NUM_FU(F), .SHARE_MODE(SHARE_BY_TYPE)) u_vfu_share_arb (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_fu_i(fu), .done_i(done),
        .grant_o(gnt_t), .stall_o(stl_t), .busy_o(bsy_t));
    vfu_share_arb #(.NUM_HARTS(H), .NUM_FU(F), .SHARE_MODE(SHARE_DEDICATED)) u_vfu_share_arb_ded (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_fu_i(fu), .done_i(done),
        .grant_o(gnt_d), .stall_o(stl_d), .busy_o(bsy_d));
    vfu_share_arb #(.NUM_HARTS(H), .NUM_FU(F), .SHARE_MODE(SHARE_ALL)) u_vfu_share_arb_shr (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_fu_i(fu), .done_i(done),
        .grant_o(gnt_a), .stall_o(stl_a), .busy_o(bsy_a));

    typedef struct packed {
        logic [2:0] req;
        logic [5:0] fu;     // {type hart2, type hart1, type hart0}
        logic [8:0] done;
        logic [2:0] grant;
        logic [2:0] stall;
        logic [8:0] busy;   // occupancy before this cycle's edge
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{3'b000, 6'b000000, 9'h000, 3'b000, 3'b000, 9'h000}, // idle after reset
        '{3'b111, 6'b100100, 9'h000, 3'b111, 3'b000, 9'h000}, // three distinct types
        '{3'b000, 6'b000000, 9'h000, 3'b000, 3'b000, 9'h007},
        '{3'b000, 6'b000000, 9'h002, 3'b000, 3'b000, 9'h007}, // multiplier done
        '{3'b101, 6'b010001, 9'h000, 3'b100, 3'b001, 9'h005}, // rr on type1 -> hart2
        '{3'b001, 6'b000001, 9'h002, 3'b000, 3'b001, 9'h007}, // done cycle, still stall
        '{3'b001, 6'b000001, 9'h000, 3'b001, 3'b000, 9'h005}, // released, grant
        '{3'b110, 6'b100000, 9'h005, 3'b000, 3'b110, 9'h007},
        '{3'b110, 6'b100000, 9'h000, 3'b110, 3'b000, 9'h002},
        '{3'b000, 6'b000000, 9'h007, 3'b000, 3'b000, 9'h007},
        '{3'b111, 6'b000000, 9'h000, 3'b100, 3'b011, 9'h000}, // rr type0 -> hart2
        '{3'b011, 6'b000000, 9'h001, 3'b000, 3'b011, 9'h001},
        '{3'b011, 6'b000000, 9'h000, 3'b001, 3'b010, 9'h000}, // wrap -> hart0
        '{3'b010, 6'b000000, 9'h001, 3'b000, 3'b010, 9'h001},
        '{3'b010, 6'b000000, 9'h000, 3'b010, 3'b000, 9'h000},
        '{3'b001, 6'b000011, 9'h001, 3'b000, 3'b000, 9'h001}, // bad type code
        '{3'b000, 6'b000000, 9'h1FE, 3'b000, 3'b000, 9'h000}, // done on idle units
        '{3'b000, 6'b000000, 9'h000, 3'b000, 3'b000, 9'h000}
    };

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] r, input logic [5:0] t, input logic [8:0] d);
        @(negedge clk);
        req = r; fu = t; done = d;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        req = '0; fu = '0; done = '0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: state held in reset
        check("R1 busy in reset", bsy_t, 9'h000);
        check("R1 grant in reset", {6'b0, gnt_t}, 9'h000);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6 R9: per-type table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].req, VEC[i].fu, VEC[i].done);
            check($sformatf("R2/R4 grant vec%0d", i), {6'b0, gnt_t}, {6'b0, VEC[i].grant});
            check($sformatf("R3/R9 stall vec%0d", i), {6'b0, stl_t}, {6'b0, VEC[i].stall});
            check($sformatf("R5/R6 busy vec%0d", i), bsy_t, VEC[i].busy);
        end

        // R8: per-hart ownership
        do_reset();
        drive(3'b111, 6'b000000, 9'h000);
        check("R8 all harts same type granted", {6'b0, gnt_d}, 9'h007);
        drive(3'b011, 6'b000100, 9'h000);
        check("R8 private busy rows", bsy_d, 9'h049);
        check("R8 hart1 other unit granted", {6'b0, gnt_d}, 9'h002);
        check("R8 hart0 stalls on own unit", {6'b0, stl_d}, 9'h001);
        drive(3'b001, 6'b000000, 9'h001);
        check("R8 stall in done cycle", {6'b0, stl_d}, 9'h001);
        drive(3'b001, 6'b000000, 9'h000);
        check("R8 grant after release", {6'b0, gnt_d}, 9'h001);
        check("R8 busy after release", bsy_d, 9'h058);

        // R7: whole-coprocessor sharing, R4 pointer starts at hart 0
        do_reset();
        drive(3'b011, 6'b000100, 9'h000);
        check("R7 R4 single grant to hart0", {6'b0, gnt_a}, 9'h001);
        check("R7 hart1 stalls", {6'b0, stl_a}, 9'h002);
        drive(3'b010, 6'b000100, 9'h000);
        check("R7 other type blocked", {6'b0, stl_a}, 9'h002);
        check("R7 one unit busy", bsy_a, 9'h001);
        drive(3'b010, 6'b000100, 9'h001);
        check("R7 stall in done cycle", {6'b0, gnt_a}, 9'h000);
        drive(3'b010, 6'b000100, 9'h000);
        check("R7 grant after release", {6'b0, gnt_a}, 9'h002);
        check("R7 busy cleared", bsy_a, 9'h000);
        drive(3'b000, 6'b000000, 9'h000);
        check("R7 multiplier busy", bsy_a, 9'h002);

        finish_run();
    end

endmodule